// File: doc/BRIEF.md
# Pretrigger Circular Sample Pointer Controller

This block produces the cell address for an analog sample memory. The memory records detector signals all the time, before anyone knows whether an event is worth keeping. While the block is armed, it steps a write pointer around a ring of cells once per sampling tick. At a 50 MHz clock a tick comes every ten cycles, which gives one cell per 200 ns. When the ring is full, new samples overwrite the oldest ones.

A trigger arrives late compared with the tracking signal that caused it. When it comes, the block stops writing at once. It then sets a read pointer to the write pointer minus a programmable lookback count, wrapping around the ring. The lookback count is set to the delay between the tracking signal and the trigger, so the first cell read is the one that belongs to the tracking signal.

The block then steps the read pointer forward through a programmable number of cells and asserts read-valid once per cell. After that it holds until a re-arm pulse returns it to sampling. Triggers that arrive while the block is busy are dropped and counted.

Top module: `pretrig_cell_pointer`

## Requirements
- R1: While armed, `sample_en_o` pulses for one cycle every TICK_DIV cycles (default 10). The first pulse comes in the TICK_DIV-th armed cycle after reset or after a re-arm.
- R2: During each sample pulse, `cell_addr_o` shows the write pointer. The write pointer starts at 0 after reset, advances by one after each pulse, and wraps from DEPTH-1 to 0 (default DEPTH is 512).
- R3: A trigger seen while armed suppresses `sample_en_o` in that same cycle. `busy_o` rises in the next cycle, and no sample pulse occurs while `busy_o` is high.
- R4: The first cell read is (W - L) mod DEPTH. W is the write pointer at the trigger, meaning the next cell to be written. L is the lookback value at the trigger.
- R5: A lookback value of DEPTH or more is treated as DEPTH-1.
- R6: `rd_valid_o` is high for exactly N consecutive cycles, starting in the cycle after the trigger. N is `rd_len_i` at the trigger. During those cycles `cell_addr_o` steps up by one per cycle from the start cell and wraps from DEPTH-1 to 0.
- R7: A readout length of 0 produces no `rd_valid_o` cycle, and the block goes straight to the held state with `busy_o` high.
- R8: A trigger while `busy_o` is high does not change the readout in progress. It increments `lost_trig_o`, which saturates at 2^LOST_W-1 (default 15) and is cleared only by reset.
- R9: A re-arm pulse takes effect only after the readout has ended. It is ignored while `rd_valid_o` is high. Sampling then resumes from the write pointer held at the trigger.
- R10: After reset, `busy_o`, `sample_en_o` and `rd_valid_o` are 0, and `cell_addr_o` and `lost_trig_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 50 MHz nominal |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Valid trigger, sampled at each clock edge |
| lookback_i | input | AW+1 | Rewind distance in cells, taken at the trigger |
| rd_len_i | input | AW+1 | Number of cells to read, taken at the trigger |
| rearm_i | input | 1 | Return to sampling after the readout |
| cell_addr_o | output | AW | Cell address: the write pointer while armed, the read pointer while busy |
| sample_en_o | output | 1 | Write strobe for the addressed cell |
| rd_valid_o | output | 1 | The addressed cell is being read |
| busy_o | output | 1 | Sampling is frozen (readout or hold) |
| lost_trig_o | output | LOST_W | Saturating count of triggers ignored while busy |

## Verification
The assertions assume that `trig_i` and `rearm_i` are clean, synchronous levels that change only between clock edges. They also assume that `lookback_i` and `rd_len_i` are stable in the cycle where a trigger is taken. The bench meets these conditions by driving every input one time unit after the rising edge and setting the lookback and length values in the same cycle as the trigger pulse. It samples outputs on the falling edge, so the combinational suppression of the sample strobe in the trigger cycle is observed as settled.

// File: rtl/cellptr_pkg.sv
// Shared types for the pretrigger cell pointer controller.
// Assumes nothing beyond a two-bit state encoding.
package cellptr_pkg;

    // Controller phase: continuous sampling, readout, or holding for re-arm
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_READ  = 2'd1,
        ST_HOLD  = 2'd2
    } cp_state_e;

endpackage

// File: rtl/cellptr_tick.sv
// Sampling tick divider: emits a one-cycle pulse every DIV cycles while en is high.
// Assumes DIV >= 2; the count restarts from zero whenever en is low.
module cellptr_tick #(
    parameter int DIV = 10,
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pulse_o
);

    logic [CW-1:0] cnt_q;

    // Count armed cycles and wrap at the end of each sampling period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Pulse in the last cycle of each period
    assign pulse_o = en && (cnt_q == CW'(DIV - 1));

    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/cellptr_ring.sv
// Circular cell pointer: loads a value or advances by one, wrapping at DEPTH-1.
// Assumes load_val < DEPTH; load has priority over advance.
module cellptr_ring #(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    output logic [AW-1:0] ptr_o
);

    logic [AW-1:0] ptr_q;

    // Hold, load or step the pointer around the ring
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (adv) begin
            ptr_q <= (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    // R2
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && ptr_q == AW'(DEPTH - 1)) |=> (ptr_q == '0));

endmodule

// File: rtl/cellptr_satcnt.sv
// Saturating event counter that stops at its all-ones value.
// Assumes inc is a single-cycle-per-event level; cleared only by reset.
module cellptr_satcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    // Increment per event until the maximum is reached
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != {W{1'b1}})) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R8
    satcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt_q != {W{1'b1}}) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R8
    satcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == {W{1'b1}}) |=> (cnt_q == {W{1'b1}}));

endmodule

// File: rtl/pretrig_cell_pointer.sv
// Pretrigger circular sample pointer controller.
// Samples continuously into a ring of DEPTH cells, freezes on a trigger, rewinds
// by a clamped lookback, reads rd_len cells forward and waits for re-arm.
// Assumes trig_i/rearm_i are synchronous; lookback_i and rd_len_i are valid with trig_i.
module pretrig_cell_pointer
    import cellptr_pkg::*;
#(
    parameter int DEPTH    = 512,
    parameter int TICK_DIV = 10,
    parameter int LOST_W   = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_i,
    input  logic [LW-1:0] lookback_i,
    input  logic [LW-1:0] rd_len_i,
    input  logic          rearm_i,
    output logic [AW-1:0] cell_addr_o,
    output logic          sample_en_o,
    output logic          rd_valid_o,
    output logic          busy_o,
    output logic [LOST_W-1:0] lost_trig_o
);

    cp_state_e     state_q, state_d;
    logic          armed, trig_take, tick_pulse;
    logic [AW-1:0] wptr, rptr, start_ptr;
    logic [LW-1:0] lb_clamped, rew_sum, remain_q;

    assign armed     = (state_q == ST_ARMED);
    assign trig_take = armed && trig_i;
    assign busy_o    = !armed;
    assign rd_valid_o = (state_q == ST_READ);

    cellptr_tick #(.DIV(TICK_DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .en(armed), .pulse_o(tick_pulse)
    );

    // A trigger in the tick cycle wins: the strobe is withheld at once
    assign sample_en_o = tick_pulse && !trig_i;

    cellptr_ring #(.DEPTH(DEPTH)) wptr_i (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
        .adv(sample_en_o), .ptr_o(wptr)
    );

    // Clamp the lookback and subtract it modulo DEPTH
    always_comb begin
        lb_clamped = (lookback_i >= LW'(DEPTH)) ? LW'(DEPTH - 1) : lookback_i;
        rew_sum    = {1'b0, wptr} + LW'(DEPTH) - lb_clamped;
        if (rew_sum >= LW'(DEPTH)) begin
            rew_sum = rew_sum - LW'(DEPTH);
        end
        start_ptr = rew_sum[AW-1:0];
    end

    cellptr_ring #(.DEPTH(DEPTH)) rptr_i (
        .clk(clk), .rst_n(rst_n), .load(trig_take), .load_val(start_ptr),
        .adv(rd_valid_o), .ptr_o(rptr)
    );

    // Track cells still to be read in this readout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (trig_take) begin
            remain_q <= rd_len_i;
        end else if (rd_valid_o) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Phase sequencing: armed -> read -> hold -> armed
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (trig_i) state_d = (rd_len_i == '0) ? ST_HOLD : ST_READ;
            ST_READ:  if (remain_q == LW'(1)) state_d = ST_HOLD;
            ST_HOLD:  if (rearm_i) state_d = ST_ARMED;
            default:  state_d = ST_HOLD;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Address mux: write side while armed, read side otherwise
    assign cell_addr_o = armed ? wptr : rptr;

    cellptr_satcnt #(.W(LOST_W)) lost_i (
        .clk(clk), .rst_n(rst_n), .inc(busy_o && trig_i), .cnt_o(lost_trig_o)
    );

    // R3
    trig_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && !busy_o) |=> busy_o);

    // R3
    no_strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(sample_en_o));

    // R6
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && $past(rd_valid_o)) |->
        (int'(cell_addr_o) == (int'($past(cell_addr_o)) + 1) % DEPTH));

    // R9
    rearm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && rearm_i) |=> busy_o);

    // R6
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> busy_o);

endmodule

// File: tb/pretrig_cell_pointer_tb_top.sv
// Scoreboard bench: driver tasks queue expected read addresses; a monitor
// checks every strobe and every read cycle as the design produces them.
module pretrig_cell_pointer_tb_top;

    localparam int CLK_PERIOD = 20;
    localparam int DEPTH = 512;
    localparam int TICK_DIV = 10;
    localparam int LOST_W = 4;
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic rearm = 1'b0;
    logic [LW-1:0] lookback = '0;
    logic [LW-1:0] rd_len = '0;
    logic [AW-1:0] cell_addr;
    logic sample_en, rd_valid, busy;
    logic [LOST_W-1:0] lost;

    int checks = 0;
    int errors = 0;
    int wmodel = 0;
    int gap = 0;
    int exp_q[$];
    bit finished = 1'b0;

    pretrig_cell_pointer #(.DEPTH(DEPTH), .TICK_DIV(TICK_DIV), .LOST_W(LOST_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .lookback_i(lookback),
        .rd_len_i(rd_len), .rearm_i(rearm), .cell_addr_o(cell_addr),
        .sample_en_o(sample_en), .rd_valid_o(rd_valid), .busy_o(busy),
        .lost_trig_o(lost)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: strobe period, write address, no strobe while busy, read scoreboard
    always @(negedge clk) begin
        if (!rst_n) begin
            gap = 0;
        end else begin
            if (busy) gap = 0; else gap++;
            if (sample_en) begin
                check(gap == TICK_DIV, "R1 strobe period", gap, TICK_DIV);
                check(int'(cell_addr) == wmodel, "R2 write address", int'(cell_addr), wmodel);
                check(!busy, "R3 strobe while busy", int'(busy), 0);
                wmodel = (wmodel + 1) % DEPTH;
                gap = 0;
            end
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected read", int'(cell_addr), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(cell_addr) == e, "R4/R6 read address", int'(cell_addr), e);
                end
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: fire a trigger while armed and queue the expected read cells
    task automatic fire(input int lb, input int len);
        int lbc, start;
        @(posedge clk); #1;
        trig = 1'b1;
        lookback = LW'(lb);
        rd_len = LW'(len);
        lbc = (lb >= DEPTH) ? DEPTH - 1 : lb;
        start = (wmodel - lbc + DEPTH) % DEPTH;
        for (int i = 0; i < len; i++) exp_q.push_back((start + i) % DEPTH);
        @(posedge clk); #1;
        trig = 1'b0;
    endtask

    task automatic pulse_trig();
        trig = 1'b1;
        @(posedge clk); #1;
        trig = 1'b0;
    endtask

    task automatic pulse_rearm();
        rearm = 1'b1;
        @(posedge clk); #1;
        rearm = 1'b0;
    endtask

    task automatic finish_readout(input string req, input int len);
        cycles(len + 2);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        check(busy == 1'b1, "R9 held after readout", int'(busy), 1);
    endtask

    initial begin
        int lost_exp;
        lost_exp = 0;
        cycles(3);
        @(negedge clk);
        // R10 reset state
        check(busy == 0 && sample_en == 0 && rd_valid == 0, "R10 reset flags",
              int'({busy, sample_en, rd_valid}), 0);
        check(cell_addr == 0 && lost == 0, "R10 reset values", int'(cell_addr) + int'(lost), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R4 basic rewind
        cycles(255);
        fire(3, 6);
        finish_readout("R6 readout length", 6);
        cycles(30);
        check(busy == 1'b1, "R9 hold without rearm", int'(busy), 1);
        pulse_rearm();
        @(negedge clk);
        check(busy == 1'b0, "R9 rearm resumes", int'(busy), 0);

        // R4 zero lookback starts at the write pointer
        cycles(47);
        fire(0, 4);
        finish_readout("R4 zero lookback", 4);
        pulse_rearm();

        // R2 write wrap, then rewind that crosses zero
        while (wmodel != 2) @(negedge clk);
        #1;
        fire(5, 8);
        finish_readout("R4 rewind wrap", 8);
        pulse_rearm();

        // R5 clamp of an oversized lookback
        cycles(33);
        fire(700, 3);
        finish_readout("R5 lookback clamp", 3);
        pulse_rearm();

        // R7 zero-length readout
        cycles(21);
        fire(2, 0);
        @(negedge clk);
        check(busy == 1'b1 && rd_valid == 1'b0, "R7 zero length",
              int'({busy, rd_valid}), 2);
        cycles(5);
        check(exp_q.size() == 0, "R7 no reads", exp_q.size(), 0);
        pulse_rearm();

        // R8 triggers during readout are ignored and counted
        cycles(40);
        fire(10, 20);
        cycles(2);
        for (int i = 0; i < 3; i++) begin
            pulse_trig();
            lost_exp++;
            cycles(1);
        end
        finish_readout("R8 readout unaffected", 20);
        @(negedge clk);
        check(int'(lost) == lost_exp, "R8 lost count", int'(lost), lost_exp);
        @(posedge clk); #1;
        for (int i = 0; i < 20; i++) pulse_trig();
        @(negedge clk);
        check(int'(lost) == 15, "R8 lost saturates", int'(lost), 15);
        @(posedge clk); #1;
        pulse_rearm();

        // R9 rearm during readout is ignored
        cycles(60);
        fire(4, 10);
        cycles(3);
        pulse_rearm();
        finish_readout("R9 readout after ignored rearm", 10);
        pulse_rearm();
        cycles(45);
        check(busy == 1'b0, "R9 armed again", int'(busy), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule